// File: doc/BRIEF.md
# Dual-Lane Programmable Delay Line

This block delays an 8-bit data word by a programmable number of clock cycles. The word is split into a low lane (bits 3..0) and a high lane (bits 7..4). Each lane has its own fixed chain of seventeen stage registers, a tap selector that can pick any of stages two through seventeen, and a final output register. Every rising edge shifts a new sample into both chains, whatever the settings. The delay therefore runs from 3 cycles (tap at stage two) to 18 cycles (tap at stage seventeen).

A 4-bit length code and a one-bit mode input are captured into a control register on every edge, and the captured value steers the tap selectors. With mode low, both lanes use the delay the code sets. With mode high, the high lane is pinned at the full 18-cycle delay and only the low lane follows the code. Changing the settings moves the taps only. The chains keep their contents, so a block that retunes its delay sees older or newer history at once, with no flush. A synchronous active-high reset, selected by a parameter, clears the chains, the output register and the control register.

Top module: `dual_delay_line`

## Requirements
- R1: A high `rst` at a rising edge clears all stage registers, the output register and the control register. `y` is zero after that edge, and the next settings are code 0 with mode 0.
- R2: With captured mode 0 and captured code N, both lanes give delay N+3. A word applied at edge e appears on `y` after edge e+N+2.
- R3: With captured mode 1, the high lane (`y[7:4]`) shows `d[7:4]` from 18 cycles earlier (applied at edge e, visible after edge e+17), whatever the code.
- R4: With captured mode 1, the low lane (`y[3:0]`) still follows the code with delay N+3.
- R5: `len_code` and `mode` applied at edge e steer the output register at edge e+1. The output after edge e itself still uses the settings captured at edge e-1.
- R6: A change of code or mode leaves the stage contents unchanged. From the first edge that uses the new settings, `y` shows the older or newer sample already held at the new tap. Samples can repeat or be skipped at the switch.
- R7: The lanes are independent. Each output bit of a lane depends only on the same bit of the same lane's input.
- R8: Code 15 in mode 0 gives 18 cycles on both lanes. This is the same delay as the high lane pinned in mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high clear (used when USE_RST=1) |
| d | input | 8 | Data word; bits 3..0 low lane, bits 7..4 high lane |
| len_code | input | 4 | Delay code, delay = code + 3 cycles |
| mode | input | 1 | 0: both lanes programmable; 1: high lane fixed at 18 |
| y | output | 8 | Delayed data word from the output registers |

## Verification
A change of settings and a data shift fall in the same cycle. The chains shift new data in on the same edge that the control register takes a new code, and the output register samples the tap chosen by the previous code. The bench provokes this by switching code and mode mid-stream, both in directed jumps (longest to shortest delay, and mode toggles) and in random changes. It judges each cycle with a reference history model that applies the one-edge control lag, so a repeated or skipped sample at the switch is expected, and any disturbed stage content is reported.

// File: rtl/dld_pkg.sv
package dld_pkg;
  localparam int unsigned DLD_CODE_W = 4;
  localparam int unsigned DLD_LANES  = 2;

  typedef struct packed {
    logic                  hold_max;
    logic [DLD_CODE_W-1:0] len;
  } dld_ctrl_t;
endpackage

// File: rtl/dld_ctrl_reg.sv
module dld_ctrl_reg
  import dld_pkg::*;
#(
  parameter int unsigned USE_RST = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DLD_CODE_W-1:0] len_in,
  input  logic                  hold_in,
  output dld_ctrl_t             ctrl_q
);
  localparam bit RST_ON = (USE_RST != 0);
  logic rst_eff;
  assign rst_eff = RST_ON & rst;

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q.len      <= len_in;
      ctrl_q.hold_max <= hold_in;
    end
  end
endmodule

// File: rtl/dld_lane.sv
module dld_lane #(
  parameter int unsigned W       = 4,
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned STAGES  = 17,
  parameter int unsigned USE_RST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      din,
  input  logic              force_max,
  input  logic [CODE_W-1:0] len,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      tail
);
  localparam int unsigned SEL_W = $clog2(STAGES);
  localparam bit          RST_ON = (USE_RST != 0);

  logic         rst_eff;
  logic [W-1:0] stage_in [STAGES];
  logic [W-1:0] stage_q  [STAGES];
  logic [SEL_W-1:0] sel;
  logic [W-1:0]     tapped;

  assign rst_eff = RST_ON & rst;

  assign stage_in[0] = din;
  for (genvar g = 1; g < STAGES; g++) begin : g_link
    assign stage_in[g] = stage_q[g-1];
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst_eff) stage_q[g] <= '0;
      else         stage_q[g] <= stage_in[g];
    end
  end

  always_comb begin
    if (force_max) sel = SEL_W'(STAGES - 1);
    else           sel = SEL_W'(len) + SEL_W'(1);
  end

  always_comb begin
    tapped = '0;
    for (int i = 1; i < STAGES; i++) begin
      if (sel == SEL_W'(i)) tapped = stage_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_eff) dout <= '0;
    else         dout <= tapped;
  end

  assign tail = stage_q[STAGES-1];
endmodule

// File: rtl/dual_delay_line.sv
module dual_delay_line
  import dld_pkg::*;
#(
  parameter int unsigned LANE_W  = 4,
  parameter int unsigned USE_RST = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DLD_LANES*LANE_W-1:0]   d,
  input  logic [DLD_CODE_W-1:0]         len_code,
  input  logic                          mode,
  output logic [DLD_LANES*LANE_W-1:0]   y
);
  localparam int unsigned STAGES = (1 << DLD_CODE_W) + 1;

  dld_ctrl_t   ctrl_q;
  logic [LANE_W-1:0] tail_w [DLD_LANES];

  dld_ctrl_reg #(.USE_RST(USE_RST)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .len_in  (len_code),
    .hold_in (mode),
    .ctrl_q  (ctrl_q)
  );

  for (genvar ln = 0; ln < DLD_LANES; ln++) begin : g_lane
    logic pin_max;
    if (ln == DLD_LANES - 1) begin : g_top
      assign pin_max = ctrl_q.hold_max;
    end else begin : g_low
      assign pin_max = 1'b0;
    end

    dld_lane #(
      .W       (LANE_W),
      .CODE_W  (DLD_CODE_W),
      .STAGES  (STAGES),
      .USE_RST (USE_RST)
    ) u_lane (
      .clk       (clk),
      .rst       (rst),
      .din       (d[ln*LANE_W +: LANE_W]),
      .force_max (pin_max),
      .len       (ctrl_q.len),
      .dout      (y[ln*LANE_W +: LANE_W]),
      .tail      (tail_w[ln])
    );
  end
endmodule

// File: rtl/dual_delay_line_chk.sv
module dual_delay_line_chk #(
  parameter int unsigned LANE_W = 4,
  parameter int unsigned CODE_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2*LANE_W-1:0]   d,
  input logic [CODE_W-1:0]     len_code,
  input logic                  mode,
  input logic [2*LANE_W-1:0]   y,
  input logic [CODE_W-1:0]     len_q,
  input logic                  hold_q,
  input logic [LANE_W-1:0]     hi_tail
);
  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                  warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (y == '0));

  a_r5_ctrl_capture: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (len_q == $past(len_code) && hold_q == $past(mode)));

  a_r2_shortest_both: assert property (@(posedge clk) disable iff (rst)
    (warm && !hold_q && len_q == '0) |=> (y == $past(d, 3)));

  a_r4_low_follows_code: assert property (@(posedge clk) disable iff (rst)
    (warm && hold_q && len_q == '0) |=> (y[LANE_W-1:0] == $past(d[LANE_W-1:0], 3)));

  a_r3_high_pinned: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (y[2*LANE_W-1:LANE_W] == $past(hi_tail)));

  a_r8_longest_code: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && len_q == '1) |=> (y[2*LANE_W-1:LANE_W] == $past(hi_tail)));
endmodule

bind dual_delay_line dual_delay_line_chk #(
  .LANE_W (LANE_W),
  .CODE_W (dld_pkg::DLD_CODE_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .d        (d),
  .len_code (len_code),
  .mode     (mode),
  .y        (y),
  .len_q    (ctrl_q.len),
  .hold_q   (ctrl_q.hold_max),
  .hi_tail  (tail_w[1])
);

// File: tb/dual_delay_line_tb.sv
module dual_delay_line_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] d = '0;
  logic [3:0] len_code = '0;
  logic       mode = 1'b0;
  logic [7:0] y;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] hist [0:17];
  logic [3:0] cq = '0;
  logic       mq = 1'b0;
  logic [7:0] exp_y = '0;
  bit         have_exp = 1'b0;
  string      pend_lo = "R1";
  string      pend_hi = "R1";

  always #5 clk = ~clk;

  dual_delay_line dut_i (
    .clk(clk), .rst(rst), .d(d), .len_code(len_code), .mode(mode), .y(y)
  );

  function automatic logic [3:0] exp_low(input logic [3:0] c);
    return hist[c + 1][3:0];
  endfunction

  function automatic logic [3:0] exp_high(input logic [3:0] c, input logic m);
    return m ? hist[16][7:4] : hist[c + 1][7:4];
  endfunction

  task automatic compare_pending();
    if (have_exp) begin
      n_cmp++;
      if (y[3:0] !== exp_y[3:0]) begin
        n_bad++;
        $display("FAIL %s low lane: got %h expected %h at %0t", pend_lo, y[3:0], exp_y[3:0], $time);
      end
      n_cmp++;
      if (y[7:4] !== exp_y[7:4]) begin
        n_bad++;
        $display("FAIL %s high lane: got %h expected %h at %0t", pend_hi, y[7:4], exp_y[7:4], $time);
      end
    end
  endtask

  task automatic cycle(input logic [7:0] dv, input logic [3:0] cv, input logic mv,
                       input logic rv, input string tlo, input string thi);
    @(negedge clk);
    compare_pending();
    d = dv; len_code = cv; mode = mv; rst = rv;
    @(posedge clk);
    if (rv) begin
      exp_y = '0;
      for (int i = 0; i < 18; i++) hist[i] = '0;
      cq = '0; mq = 1'b0;
    end else begin
      exp_y = {exp_high(cq, mq), exp_low(cq)};
      for (int i = 17; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = dv;
      cq = cv; mq = mv;
    end
    pend_lo = tlo; pend_hi = thi;
    have_exp = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 18; i++) hist[i] = '0;
    // R1: reset from time zero, then again after dirtying the chains
    cycle(8'h00, 4'd0, 1'b0, 1'b1, "R1", "R1");
    cycle(8'h00, 4'd0, 1'b0, 1'b1, "R1", "R1");
    for (int i = 0; i < 20; i++) cycle(8'hA5 ^ 8'(i), 4'd7, 1'b1, 1'b0, "R4", "R3");
    cycle(8'hFF, 4'd9, 1'b1, 1'b1, "R1", "R1");
    for (int i = 0; i < 6; i++) cycle(8'(8'h11 * (i + 1)), 4'd0, 1'b0, 1'b0, "R1", "R1");

    // R2: every code in mode 0, counting pattern
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 22; i++) cycle(8'(c * 16 + i), 4'(c), 1'b0, 1'b0, "R2", "R2");

    // R3 / R4: every code in mode 1
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 22; i++) cycle(8'(8'h80 + c * 7 + i), 4'(c), 1'b1, 1'b0, "R4", "R3");

    // R8: longest code in mode 0
    for (int i = 0; i < 24; i++) cycle(8'(i * 13), 4'd15, 1'b0, 1'b0, "R8", "R8");

    // R5 / R6: jump longest to shortest and back, mode toggles, history kept
    for (int i = 0; i < 20; i++) cycle(8'(i + 1), 4'd15, 1'b0, 1'b0, "R6", "R6");
    cycle(8'h40, 4'd0, 1'b0, 1'b0, "R5", "R5");
    cycle(8'h41, 4'd0, 1'b0, 1'b0, "R6", "R6");
    for (int i = 0; i < 4; i++) cycle(8'(8'h42 + i), 4'd0, 1'b0, 1'b0, "R6", "R6");
    cycle(8'h50, 4'd15, 1'b0, 1'b0, "R5", "R5");
    for (int i = 0; i < 6; i++) cycle(8'(8'h51 + i), 4'd15, 1'b0, 1'b0, "R6", "R6");
    cycle(8'h60, 4'd3, 1'b1, 1'b0, "R5", "R5");
    for (int i = 0; i < 6; i++) cycle(8'(8'h61 + i), 4'd3, 1'b0, 1'b0, "R6", "R6");

    // R7: random data, random settings changing at random moments
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] rc;
      logic       rm;
      rc = 4'($urandom_range(0, 15));
      rm = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 7) != 0) begin rc = cq; rm = mq; end
      cycle(8'($urandom), rc, rm, 1'b0, "R7", "R7");
    end

    @(negedge clk);
    compare_pending();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule